// File: doc/BRIEF.md
# Watchdog Guard Timer

The block is a watchdog timer for a small controller. It counts strobes from a slow, free-running oscillator. One strobe marks one oscillator cycle and lasts one system clock. When software stops restarting the timer, the block raises an interrupt, requests a system reset, or does both in turn. A four-bit period select chooses the time-out. The time-out is 2^(BASE_LOG2 + select) strobes. The default base gives 2048 strobes at select 0.

Software reaches the block through an 8-bit port with two addresses. Address 0 is the control register: bit 7 is the event flag, bit 6 is the interrupt enable, bit 3 is the reset enable, and bits 5 and 2:0 form the period select, with bit 5 as its most significant bit. Bit 4 reads zero. Address 1 is the unlock port and reads zero. The reset enable and the period select are protected fields. They change only when the control write follows a write of the unlock key 0xC3 to address 1 closely enough. A fuse input pins the block in reset-only behaviour.

A state machine sets the behaviour. Its states are OFF, IRQ, RESET, WARN, LAST and FIRE. The register decode moves the machine between OFF, IRQ, RESET and WARN. In IRQ, a time-out sets the flag and the machine stays in IRQ. In RESET, a time-out goes to FIRE. In WARN, a time-out sets the flag, clears the interrupt enable and goes to LAST. In LAST, a time-out goes to FIRE, and a restart returns to WARN with the interrupt enable set again. LAST also leaves to WARN, OFF or IRQ when software changes the enables. FIRE holds the reset request and returns to the decoded state when the reset is acknowledged.

Top module: `watchdog_guard`

## Requirements
- R1: After reset, with the fuse input low, the control register reads 0x00 and both irq and sys_rst_req are low.
- R2: In a running mode, a time-out occurs on the 2^(BASE_LOG2+s)-th slow_tick after a restart. s is the period select {ctrl[5], ctrl[2:0]}, and select values above 9 act as 9.
- R3: A restart sets the count to zero, so the next time-out comes a full period after the last restart.
- R4: With ctrl[6]=1 and ctrl[3]=0, a time-out sets the flag (ctrl[7]) and irq, and never requests a reset; counting continues.
- R5: The flag is cleared by a control write with bit 7 set, or by an irq_ack pulse. A control write with bit 7 clear leaves the flag unchanged.
- R6: With ctrl[6]=1 and ctrl[3]=1, the first time-out sets the flag and clears ctrl[6]. A second time-out with no restart in between raises sys_rst_req.
- R7: A restart after the first time-out of the combined mode sets ctrl[6] again. The next time-out then only sets the flag and clears ctrl[6] again.
- R8: With ctrl[3]=1 and ctrl[6]=0, a time-out raises sys_rst_req and leaves the flag clear.
- R9: sys_rst_req stays high until a sys_rst_ack pulse. After the acknowledge the count starts again from zero.
- R10: While fuse_force is high, ctrl[3] reads 1, a time-out always raises sys_rst_req, and the flag is never set, whatever ctrl[6] holds.
- R11: ctrl[3] and the select bits take a write only in the 4 cycles that follow a write of 0xC3 to address 1. Any other write leaves them unchanged. ctrl[6] and ctrl[7] are not protected.
- R12: With both enables clear and the fuse low, the count is stopped, and neither irq nor sys_rst_req rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow oscillator cycle |
| restart | input | 1 | Restart command pulse |
| fuse_force | input | 1 | Fuse level forcing reset-only behaviour |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control, 1 = unlock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Interrupt request (mirrors the flag) |
| irq_ack | input | 1 | Interrupt taken pulse; clears the flag |
| sys_rst_req | output | 1 | System reset request, held until acknowledged |
| sys_rst_ack | input | 1 | Acknowledge for the reset request |

## Verification
The time-out path is tried with each mode the enables select: interrupt only, reset only, combined, disabled, and fuse forced. Each run looks for an event at an exact strobe count after a restart or an acknowledge. This separates a miscounted period, a wrong decode of the select bits, and a wrong action on time-out. The select is tried at 0, 1, a value using only the high bit, and a value above the limit, so a lost or misplaced bit changes the measured period. Protected writes are made right after the key, at the last cycle of the window, one cycle late, and with no key. This finds a window that is too short or too long. In the combined mode the flag is cleared through irq_ack, which does not touch the enable. That shows whether the restart alone restores the interrupt stage.

// File: rtl/watchdog_guard_pkg.sv
package watchdog_guard_pkg;

    typedef enum logic [2:0] {
        WD_OFF   = 3'd0,
        WD_IRQ   = 3'd1,
        WD_RESET = 3'd2,
        WD_WARN  = 3'd3,
        WD_LAST  = 3'd4,
        WD_FIRE  = 3'd5
    } wd_state_t;

    // Behaviour selected by the stored enables and the fuse level
    function automatic wd_state_t decode_mode(input logic ie, input logic re, input logic fuse);
        if (fuse)
            return WD_RESET;
        else if (ie && re)
            return WD_WARN;
        else if (re)
            return WD_RESET;
        else if (ie)
            return WD_IRQ;
        else
            return WD_OFF;
    endfunction

endpackage

// File: rtl/watchdog_guard_unlock.sv
module watchdog_guard_unlock #(
    parameter int          WIN_LEN = 4,
    parameter logic [7:0]  KEY     = 8'hC3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] wdata,
    output logic       win_open
);
    localparam int WW = $clog2(WIN_LEN + 1);

    logic [WW-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_q <= '0;
        else if (key_wr)
            win_q <= (wdata == KEY) ? WW'(WIN_LEN) : '0;
        else if (win_q != '0)
            win_q <= win_q - 1'b1;
    end

    assign win_open = (win_q != '0);

    // R11: a correct key always opens the window on the next cycle
    assert_key_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata == KEY) |=> win_open);

endmodule

// File: rtl/watchdog_guard_counter.sv
module watchdog_guard_counter #(
    parameter int BASE_LOG2 = 11,
    parameter int SEL_MAX   = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic       tick,
    input  logic [3:0] sel,
    output logic       expire
);
    localparam int CNT_W = BASE_LOG2 + SEL_MAX;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [3:0]       sel_c;
    logic [3:0]       shamt;

    always_comb begin
        sel_c  = (sel > 4'(SEL_MAX)) ? 4'(SEL_MAX) : sel;
        shamt  = 4'(SEL_MAX) - sel_c;
        limit  = {CNT_W{1'b1}} >> shamt;
        expire = run && !clear && tick && (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end

    // R3: straight after a restart the period cannot already be over
    assert_no_expire_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expire);

endmodule

// File: rtl/watchdog_guard_fsm.sv
module watchdog_guard_fsm
    import watchdog_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      expire,
    input  logic      restart,
    input  logic      rst_ack,
    input  wd_state_t mode,
    output logic      set_flag,
    output logic      clr_ie,
    output logic      set_ie,
    output logic      cnt_run,
    output logic      rst_req
);
    wd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WD_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF, WD_IRQ:
                state_d = mode;
            WD_RESET:
                state_d = expire ? WD_FIRE : mode;
            WD_WARN:
                state_d = expire ? WD_LAST : mode;
            WD_LAST: begin
                if (expire)
                    state_d = WD_FIRE;
                else if (restart)
                    state_d = WD_WARN;
                else if (mode != WD_RESET)
                    state_d = mode;
            end
            WD_FIRE:
                state_d = rst_ack ? mode : WD_FIRE;
            default:
                state_d = WD_OFF;
        endcase
    end

    always_comb begin
        set_flag = 1'b0;
        clr_ie   = 1'b0;
        set_ie   = 1'b0;
        cnt_run  = 1'b1;
        rst_req  = 1'b0;
        unique case (state_q)
            WD_OFF:   cnt_run  = 1'b0;
            WD_IRQ:   set_flag = expire;
            WD_RESET: ;
            WD_WARN: begin
                set_flag = expire;
                clr_ie   = expire;
            end
            WD_LAST:  set_ie   = restart && !expire;
            WD_FIRE: begin
                cnt_run  = 1'b0;
                rst_req  = 1'b1;
            end
            default:  cnt_run  = 1'b0;
        endcase
    end

    // R9: the reset request persists until acknowledged
    assert_rst_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !rst_ack) |=> rst_req);

    // R8: a time-out in reset-only behaviour raises the request
    assert_reset_on_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RESET && expire) |=> rst_req);

    // R6: a second time-out in the combined behaviour raises the request
    assert_second_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_LAST && expire) |=> rst_req);

endmodule

// File: rtl/watchdog_guard.sv
module watchdog_guard
    import watchdog_guard_pkg::*;
#(
    parameter int         BASE_LOG2 = 11,
    parameter int         SEL_MAX   = 9,
    parameter int         WIN_LEN   = 4,
    parameter logic [7:0] KEY       = 8'hC3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       restart,
    input  logic       fuse_force,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    input  logic       irq_ack,
    output logic       sys_rst_req,
    input  logic       sys_rst_ack
);
    logic       flag_q, ie_q, re_q;
    logic [3:0] sel_q;
    logic       win_open, ctrl_wr, key_wr;
    logic       expire, set_flag, clr_ie, set_ie, cnt_run;
    logic       re_eff;
    wd_state_t  mode;

    assign ctrl_wr = bus_wr && !bus_addr;
    assign key_wr  = bus_wr &&  bus_addr;
    assign re_eff  = re_q || fuse_force;
    assign mode    = decode_mode(ie_q, re_q, fuse_force);

    watchdog_guard_unlock #(.WIN_LEN(WIN_LEN), .KEY(KEY)) unlock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .wdata    (bus_wdata),
        .win_open (win_open)
    );

    watchdog_guard_counter #(.BASE_LOG2(BASE_LOG2), .SEL_MAX(SEL_MAX)) counter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cnt_run),
        .clear  (restart),
        .tick   (slow_tick),
        .sel    (sel_q),
        .expire (expire)
    );

    watchdog_guard_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .restart  (restart),
        .rst_ack  (sys_rst_ack),
        .mode     (mode),
        .set_flag (set_flag),
        .clr_ie   (clr_ie),
        .set_ie   (set_ie),
        .cnt_run  (cnt_run),
        .rst_req  (sys_rst_req)
    );

    // Protected fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            re_q  <= 1'b0;
            sel_q <= '0;
        end else if (ctrl_wr && win_open) begin
            re_q  <= bus_wdata[3];
            sel_q <= {bus_wdata[5], bus_wdata[2:0]};
        end
    end

    // Interrupt enable: hardware updates win over software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ie_q <= 1'b0;
        else if (set_ie)
            ie_q <= 1'b1;
        else if (clr_ie)
            ie_q <= 1'b0;
        else if (ctrl_wr)
            ie_q <= bus_wdata[6];
    end

    // Event flag: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_flag)
            flag_q <= 1'b1;
        else if (irq_ack || (ctrl_wr && bus_wdata[7]))
            flag_q <= 1'b0;
    end

    assign irq       = flag_q;
    assign bus_rdata = bus_addr ? 8'h00
                                : {flag_q, ie_q, sel_q[3], 1'b0, re_eff, sel_q[2:0]};

    // R11: protected fields only move while the window is open
    assert_protected_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((re_q != $past(re_q)) || (sel_q != $past(sel_q))) |-> $past(win_open));

    // R6: first combined-mode time-out drops the interrupt enable
    assert_ie_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ie && !set_ie) |=> !ie_q);

endmodule

// File: tb/watchdog_guard_tb_top.sv
module watchdog_guard_tb_top;
    localparam int BL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b1;
    logic       restart = 1'b0;
    logic       fuse_force = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       irq_ack = 1'b0;
    logic       sys_rst_req;
    logic       sys_rst_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    watchdog_guard #(.BASE_LOG2(BL)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .restart     (restart),
        .fuse_force  (fuse_force),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq         (irq),
        .irq_ack     (irq_ack),
        .sys_rst_req (sys_rst_req),
        .sys_rst_ack (sys_rst_ack)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(output logic [7:0] v);
        bus_addr = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic config_ctrl(input logic [7:0] d);
        wr(1'b1, 8'hC3);
        wr(1'b0, d);
        idle(2);
    endtask

    task automatic pulse(input int which);
        if (which == 0) restart = 1'b1;
        else if (which == 1) sys_rst_ack = 1'b1;
        else irq_ack = 1'b1;
        @(negedge clk);
        restart = 1'b0; sys_rst_ack = 1'b0; irq_ack = 1'b0;
    endtask

    // Start a period with a pulse and check the event lands on strobe n exactly
    task automatic check_period(input int n, input int start, input bit on_rst, input string tag);
        pulse(start);
        idle(n - 1);
        check((on_rst ? sys_rst_req : irq) == 1'b0, {tag, " early"}, on_rst ? sys_rst_req : irq, 0);
        idle(1);
        check((on_rst ? sys_rst_req : irq) == 1'b1, {tag, " on time"}, on_rst ? sys_rst_req : irq, 1);
    endtask

    task automatic do_reset(input logic fuse);
        fuse_force = fuse;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        rd(v);
        check(v == 8'h00, "R1 ctrl after reset", v, 8'h00);
        check(irq == 0 && sys_rst_req == 0, "R1 outputs after reset", {irq, sys_rst_req}, 0);
    endtask

    task automatic t_disabled();
        pulse(0);
        idle(100);
        check(irq == 0 && sys_rst_req == 0, "R12 disabled no event", {irq, sys_rst_req}, 0);
    endtask

    task automatic t_protect();
        logic [7:0] v;
        wr(1'b0, 8'h0B); rd(v);
        check(v == 8'h00, "R11 no key ignored", v, 8'h00);
        wr(1'b1, 8'hC3); idle(4); wr(1'b0, 8'h0B); rd(v);
        check(v == 8'h00, "R11 late write ignored", v, 8'h00);
        wr(1'b1, 8'hC3); idle(3); wr(1'b0, 8'h01); rd(v);
        check(v == 8'h01, "R11 last window cycle", v, 8'h01);
        wr(1'b0, 8'h40); rd(v);
        check(v == 8'h41, "R11 ie unprotected", v, 8'h41);
        wr(1'b0, 8'h0E); rd(v);
        check(v == 8'h01, "R11 sel kept without key", v, 8'h01);
        config_ctrl(8'h00); rd(v);
        check(v == 8'h00, "R11 write right after key", v, 8'h00);
    endtask

    task automatic t_int_and_flag();
        logic [7:0] v;
        config_ctrl(8'h40);
        check_period(16, 0, 1'b0, "R4 R2 sel0");
        rd(v);
        check(v == 8'hC0, "R4 flag bit", v, 8'hC0);
        idle(20);
        check(sys_rst_req == 0, "R4 no reset", sys_rst_req, 0);
        wr(1'b0, 8'h40); rd(v);
        check(v[7] == 1'b1, "R5 write zero keeps flag", v, 8'hC0);
        wr(1'b0, 8'hC0); rd(v);
        check(v[7] == 1'b0 && irq == 0, "R5 write one clears flag", v, 8'h40);
        idle(18);
        check(irq == 1, "R4 keeps counting", irq, 1);
        pulse(2);
        check(irq == 0, "R5 irq_ack clears flag", irq, 0);
        wr(1'b0, 8'h80);
    endtask

    task automatic t_restart();
        config_ctrl(8'h40);
        pulse(0);
        idle(10);
        check_period(16, 0, 1'b0, "R3 restart mid count");
        wr(1'b0, 8'h80);
    endtask

    task automatic t_periods();
        config_ctrl(8'hC1);
        check_period(32, 0, 1'b0, "R2 sel1");
        config_ctrl(8'hE0);
        check_period(4096, 0, 1'b0, "R2 sel8");
        config_ctrl(8'hE7);
        check_period(8192, 0, 1'b0, "R2 sel15 clamp");
        config_ctrl(8'h80);
    endtask

    task automatic t_reset_mode();
        logic [7:0] v;
        config_ctrl(8'h08);
        check_period(16, 0, 1'b1, "R8 reset timeout");
        check(irq == 0, "R8 no flag", irq, 0);
        idle(25);
        check(sys_rst_req == 1, "R9 request held", sys_rst_req, 1);
        check_period(16, 1, 1'b1, "R9 count after ack");
        pulse(1);
        config_ctrl(8'h00); rd(v);
        check(v == 8'h00 && sys_rst_req == 0, "R9 released", v, 0);
    endtask

    task automatic t_combined();
        logic [7:0] v;
        config_ctrl(8'hC8);
        check_period(16, 0, 1'b0, "R6 first timeout");
        rd(v);
        check(v == 8'h88, "R6 ie cleared", v, 8'h88);
        check(sys_rst_req == 0, "R6 no reset yet", sys_rst_req, 0);
        pulse(2);
        check_period(16, 0, 1'b0, "R7 restart rearms");
        rd(v);
        check(v == 8'h88 && sys_rst_req == 0, "R7 interrupt only", {sys_rst_req, v}, 8'h88);
        pulse(2);
        idle(18);
        check(sys_rst_req == 1, "R6 second timeout resets", sys_rst_req, 1);
        pulse(1);
        config_ctrl(8'h80);
    endtask

    task automatic t_fuse();
        logic [7:0] v;
        do_reset(1'b1);
        rd(v);
        check(v == 8'h08, "R10 reads reset enable", v, 8'h08);
        check_period(16, 0, 1'b1, "R10 forced reset");
        check(irq == 0, "R10 no flag", irq, 0);
        pulse(1);
        wr(1'b0, 8'h40);
        idle(2);
        check_period(16, 0, 1'b1, "R10 ie ignored");
        rd(v);
        check(v == 8'h48 && irq == 0, "R10 ie set no flag", v, 8'h48);
        pulse(1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        t_reset_state();
        t_disabled();
        t_protect();
        t_int_and_flag();
        t_restart();
        t_periods();
        t_reset_mode();
        t_combined();
        t_fuse();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule